// File: doc/BRIEF.md
# Bidirectional General-Purpose Port with Pull-up Control

This block is an 8-pin general-purpose port that sits on a small register bus. It holds three registers:
- an output latch;
- a per-pin direction register, where a 1 means the pin is an input;
- a one-bit control register that carries an active-low pull-up enable shared by all pins.

For every pin it drives an output value, an output enable and a pull-up enable toward an external pad. Peripherals elsewhere in the chip can ask for a pin to be forced to output or to input. Such a request wins over the direction register for as long as it is held.

Software writes the latch, the direction bits and the pull-up control through a one-cycle write strobe. Reads are registered: one read strobe captures the selected register into the read data output on the next edge. Reading the data address returns the pin levels as seen through a two-flop synchronizer, not the latch. Reading the direction address returns the stored bits, not the direction that results after peripheral requests.

Address map, which the bench relies on:

| Address | Register |
|---|---|
| 0 | Data |
| 1 | Direction |
| 2 | Control (bit 0 is the pull-up disable) |
| 3 | Unused |

Top module: `gpio_port`

## Requirements
- R1: After reset:
  - the direction register is 0xFF and the output latch is 0x00;
  - the control bit 0 is 1, so pull-ups are off;
  - `pad_oe` is 0x00, `pad_pu` is 0x00 and `bus_rdata` is 0x00.
- R2: With no peripheral request on a pin, the pin's `pad_oe` bit is the inverse of its direction bit, from the cycle after the direction write.
- R3: A write to address 0 updates the output latch whatever the direction bits are. `pad_out` always carries the latch value.
- R4: Writing 0 to control bit 0 turns on `pad_pu` for every pin that is effectively an input. Writing 1 turns all pull-ups off.
- R5: A pin that is effectively an output never has its `pad_pu` bit set.
- R6: A `force_out` bit drives that pin's `pad_oe` to 1 regardless of its direction bit.
- R7: A `force_in` bit without `force_out` drives that pin's `pad_oe` to 0 regardless of its direction bit.
- R8: When `force_out` and `force_in` are both set on a pin, the pin is an output.
- R9: A read of address 0 returns the pin levels through two synchronizing flops. A level applied before edge k is returned by a read strobed at edge k+2 or later.
- R10: A read of address 1 returns the stored direction bits, unaffected by peripheral requests.
- R11: Address 3 ignores writes and reads as 0x00. Control bits 7..1 read as 0.
- R12: `bus_rdata` changes only on an edge where `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| force_out | input | 8 | Per-pin peripheral request to drive the pin |
| force_in | input | 8 | Per-pin peripheral request to float the pin |
| pin_in | input | 8 | Pin levels from the pad |
| pad_out | output | 8 | Value driven when enabled |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
The properties assume that the strobes and the address are stable around each rising edge. They also assume that peripheral requests are plain levels that may change in any cycle, with both request kinds allowed on the same pin at once. The bench changes every input a quarter period after the rising edge and samples at the falling edge, so each property sees settled values. Pin levels are treated as asynchronous, and the properties make no claim about them beyond the read path's latency, which the bench's history model covers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] out_latch,
    output logic [WIDTH-1:0] dir_bits,
    output logic             pu_dis
);
    localparam logic [WIDTH-1:0] DIR_RST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_latch <= '0;
            dir_bits  <= DIR_RST;
            pu_dis    <= 1'b1;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA: out_latch <= wdata;
                SEL_DIR:  dir_bits  <= wdata;
                SEL_CTRL: pu_dis    <= wdata[0];
                SEL_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] out_latch,
    input  logic [WIDTH-1:0] dir_bits,
    input  logic             pu_dis,
    input  logic [WIDTH-1:0] force_out,
    input  logic [WIDTH-1:0] force_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic drive;
        always_comb begin
            // a drive request outranks a float request, which outranks the register
            if (force_out[p])     drive = 1'b1;
            else if (force_in[p]) drive = 1'b0;
            else                  drive = ~dir_bits[p];
        end
        assign pad_oe[p]  = drive;
        assign pad_out[p] = out_latch[p];
        assign pad_pu[p]  = ~pu_dis & ~drive;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] force_out,
    input  logic [PORT_W-1:0] force_in,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu
);
    localparam int SYNC_STAGES = 2;

    reg_sel_e          sel;
    logic [PORT_W-1:0] out_latch;
    logic [PORT_W-1:0] dir_bits;
    logic              pu_dis;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] rd_next;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.WIDTH(PORT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .out_latch (out_latch),
        .dir_bits  (dir_bits),
        .pu_dis    (pu_dis)
    );

    gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pin_ctrl #(.WIDTH(PORT_W)) u_pins (
        .out_latch (out_latch),
        .dir_bits  (dir_bits),
        .pu_dis    (pu_dis),
        .force_out (force_out),
        .force_in  (force_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_next = pin_sync;
            SEL_DIR:  rd_next = dir_bits;
            SEL_CTRL: rd_next = {{(PORT_W-1){1'b0}}, pu_dis};
            SEL_NONE: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] force_out,
    input logic [PORT_W-1:0] force_in,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_pu
);
    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=>
        ((pad_oe & ~force_out & ~force_in) == (~$past(bus_wdata) & ~force_out & ~force_in)));

    // R3
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (pad_out == $past(bus_wdata)));

    // R5
    pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R6
    force_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & force_out) == force_out);

    // R7
    force_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & force_in & ~force_out) == '0);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .force_out (force_out),
    .force_in  (force_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] force_out = 8'h00, force_in = 8'h00, pin_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port uut (.*);

    // behavioural reference
    logic [7:0] m_latch, m_dir, m_rdata;
    logic       m_pudis;
    logic [7:0] hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = 8'h00; m_dir = 8'hFF; m_pudis = 1'b1; m_rdata = 8'h00;
            hist = {8'h00, 8'h00};
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: m_rdata = hist[hist.size()-2];
                    2'd1: m_rdata = m_dir;
                    2'd2: m_rdata = {7'b0, m_pudis};
                    default: m_rdata = 8'h00;
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_latch = bus_wdata;
                    2'd1: m_dir = bus_wdata;
                    2'd2: m_pudis = bus_wdata[0];
                    default: ;
                endcase
            end
            hist.push_back(pin_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = force_out[i] ? 1'b1 : (force_in[i] ? 1'b0 : ~m_dir[i]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 pad_out", pad_out, m_latch);
            check("R2/R6/R7/R8 pad_oe", pad_oe, exp_oe());
            check("R4/R5 pad_pu", pad_pu, m_pudis ? 8'h00 : ~exp_oe());
            check("R9/R10/R12 rdata", bus_rdata, m_rdata);
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #5;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #5;
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        @(posedge clk); #5;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #5;
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 latch", pad_out, 8'h00);
        do_read(2'd1, v); check("R1 dir", v, 8'hFF);
        do_read(2'd2, v); check("R1 ctrl", v, 8'h01);

        // R3 latch updates while all pins are inputs
        do_write(2'd0, 8'hA5);
        check("R3 latch", pad_out, 8'hA5);
        check("R3 oe", pad_oe, 8'h00);

        // R2 direction
        do_write(2'd1, 8'h0F);
        check("R2 oe", pad_oe, 8'hF0);

        // R4 R5 pull-ups
        do_write(2'd2, 8'h00);
        check("R4 pu", pad_pu, 8'h0F);

        // R6 force output
        @(posedge clk); #5 force_out = 8'h01;
        #1 check("R6 oe", pad_oe, 8'hF1);
        check("R5 pu", pad_pu, 8'h0E);
        // R7 force input
        @(posedge clk); #5 force_in = 8'h10;
        #1 check("R7 oe", pad_oe, 8'hE1);
        check("R7 pu", pad_pu, 8'h1E);
        // R8 both requests
        @(posedge clk); #5 force_out = 8'h03; force_in = 8'h12;
        #1 check("R8 oe", pad_oe, 8'hE3);

        // R10 direction read ignores requests
        do_read(2'd1, v); check("R10 dir", v, 8'h0F);

        // R9 synchronizer latency
        @(posedge clk); #5 pin_in = 8'h3C;
        do_read(2'd0, v); check("R9 early", v, 8'h00);
        do_read(2'd0, v); check("R9 late", v, 8'h3C);

        // R11 unused address and control upper bits
        do_write(2'd3, 8'hFF);
        check("R11 latch", pad_out, 8'hA5);
        check("R11 oe", pad_oe, 8'hE3);
        do_read(2'd3, v); check("R11 read3", v, 8'h00);
        do_write(2'd2, 8'hFE);
        do_read(2'd2, v); check("R11 ctrl", v, 8'h00);

        // R12 rdata holds without a read strobe
        @(posedge clk); #5 pin_in = 8'hC3; bus_addr = 2'd1;
        repeat (4) @(posedge clk);
        #5 check("R12 hold", bus_rdata, 8'h00);

        // R4 pull-ups off again
        force_out = 8'h00; force_in = 8'h00;
        do_write(2'd2, 8'h01);
        check("R4 off", pad_pu, 8'h00);

        // mixed pattern, R2
        do_write(2'd1, 8'h5A);
        do_write(2'd0, 8'h0F);
        check("R2 oe2", pad_oe, 8'hA5);
        check("R3 latch2", pad_out, 8'h0F);
        repeat (5) @(posedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule